// File: doc/BRIEF.md
# Sync Output Selector with One-Shot

This block decides what the chip presents on its sync output pin and generates a pulse that software can request. It watches an external sync input and a terminal-count pulse from a free-running counter. It also watches a small register bus. One control register carries a two-bit source select and a sync-disable bit. A separate write-only address fires the one-shot pulse. The block also drives a reload strobe that resets the counter to zero when a sync arrives, unless sync is disabled. In that case the counter free-runs.

The possible sync output sources are:
- the sync input delayed by four clocks,
- the terminal count,
- the one-shot pulse,
- nothing at all.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational.

Top module: `syncsel_top`

## Requirements
- R1: After reset, `sync_out` and `one_shot` are low, and the control register reads back 0 (select 0, sync enabled).
- R2: With select = 0 and disable = 0, `sync_out` equals `sync_in` as sampled four rising clock edges earlier.
- R3: With select = 0 and disable = 1, `sync_out` stays low whatever `sync_in` does.
- R4: With select = 1, `sync_out` follows `tc_in` in the same cycle.
- R5: With select = 2, `sync_out` equals `one_shot`.
- R6: With select = 3, `sync_out` is never asserted.
- R7: A write to address 11 sets `one_shot` high for exactly the one cycle after the write edge, whatever the write data is, and leaves the control register unchanged.
- R8: The control register is at address 10. The select field is at bits 9:8 and the disable bit at bit 10; all other bits read as zero. Reads of address 11 return zero.
- R9: `cnt_reload` equals `sync_in` while disable = 0, and stays low while disable = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| sync_in | input | 1 | External sync input |
| tc_in | input | 1 | Counter terminal-count pulse |
| sync_out | output | 1 | Selected sync output |
| one_shot | output | 1 | Software one-shot pulse |
| cnt_reload | output | 1 | Counter reload-to-zero strobe |

## Verification
The bench sends a single-cycle sync pulse and checks that it appears only in the fourth cycle. An off-by-one delay line would show the pulse one cycle early or late. With sync disabled, it checks that both `sync_out` and `cnt_reload` stay silent. A design that gated only one of them would leak a sync into the counter or onto the pin. The bench fires the one-shot with all-ones and all-zeros data and then reads the control register back. A design that decoded the data, or let address 11 alias onto the control register, would miss the pulse or corrupt the select field. A pulse stretched to two cycles would show up in the width check.

// File: rtl/syncsel_pkg.sv
package syncsel_pkg;
  typedef enum logic [1:0] {
    SRC_DSYNC = 2'd0,
    SRC_TC    = 2'd1,
    SRC_OS    = 2'd2,
    SRC_NONE  = 2'd3
  } src_sel_t;
endpackage

// File: rtl/syncsel_regs.sv
module syncsel_regs #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 10,
  parameter int OS_ADDR   = 11,
  parameter int SEL_LSB   = 8,
  parameter int DIS_BIT   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output syncsel_pkg::src_sel_t sel,
  output logic                  sync_dis,
  output logic                  os_pulse
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] OS_A   = ADDR_W'(OS_ADDR);

  logic ctrl_hit, os_hit;
  assign ctrl_hit = wr_en && (wr_addr == CTRL_A);
  assign os_hit   = wr_en && (wr_addr == OS_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= syncsel_pkg::SRC_DSYNC;
      sync_dis <= 1'b0;
      os_pulse <= 1'b0;
    end else begin
      os_pulse <= os_hit;
      if (ctrl_hit) begin
        sel      <= syncsel_pkg::src_sel_t'(wr_data[SEL_LSB +: 2]);
        sync_dis <= wr_data[DIS_BIT];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A) begin
      rd_data[SEL_LSB +: 2] = sel;
      rd_data[DIS_BIT]      = sync_dis;
    end
  end

  // R7
  os_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_pulse |-> $past(wr_en && (wr_addr == OS_A)));
  // R7
  os_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_hit) |-> ($stable(sel) && $stable(sync_dis)));
endmodule

// File: rtl/syncsel_delay.sv
module syncsel_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stg;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else if (i == 0) stg[i] <= din;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/syncsel_top.sv
module syncsel_top #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 10,
  parameter int OS_ADDR   = 11,
  parameter int SEL_LSB   = 8,
  parameter int DIS_BIT   = 10,
  parameter int SYNC_DLY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sync_in,
  input  logic              tc_in,
  output logic              sync_out,
  output logic              one_shot,
  output logic              cnt_reload
);
  import syncsel_pkg::*;

  src_sel_t sel;
  logic     sync_dis, dsync;

  syncsel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .OS_ADDR(OS_ADDR), .SEL_LSB(SEL_LSB), .DIS_BIT(DIS_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel(sel), .sync_dis(sync_dis), .os_pulse(one_shot)
  );

  syncsel_delay #(.DEPTH(SYNC_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .dout(dsync)
  );

  always_comb begin
    unique case (sel)
      SRC_DSYNC: sync_out = dsync & ~sync_dis;
      SRC_TC:    sync_out = tc_in;
      SRC_OS:    sync_out = one_shot;
      default:   sync_out = 1'b0;
    endcase
  end

  assign cnt_reload = sync_in & ~sync_dis;

  // R6
  never_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_NONE) |-> !sync_out);
  // R4
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_TC) |-> (sync_out == tc_in));
  // R9
  reload_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_dis |-> !cnt_reload);
  // R3
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_dis && sel == SRC_DSYNC) |-> !sync_out);
endmodule

// File: tb/sim_syncsel_top.sv
module sim_syncsel_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic sync_in = 1'b0, tc_in = 1'b0;
  logic sync_out, one_shot, cnt_reload;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncsel_top u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(logic [1:0] sel, logic dis);
    write(4'd10, {5'b0, dis, sel, 8'h00});
  endtask

  task automatic t_reset();
    rd_addr = 4'd10; #1;
    check("R1 ctrl", rd_data, 16'h0000);
    check("R1 sync_out", {15'b0, sync_out}, 16'h0);
    check("R1 one_shot", {15'b0, one_shot}, 16'h0);
  endtask

  task automatic t_delay();
    set_ctrl(2'd0, 1'b0);
    repeat (5) @(negedge clk);
    sync_in = 1'b1;
    #1 check("R9 reload", {15'b0, cnt_reload}, 16'h1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      sync_in = 1'b0;
      check($sformatf("R2 cyc%0d", k), {15'b0, sync_out}, (k == 4) ? 16'h1 : 16'h0);
    end
  endtask

  task automatic t_disable();
    set_ctrl(2'd0, 1'b1);
    rd_addr = 4'd10; #1;
    check("R8 ctrl dis", rd_data, 16'h0400);
    @(negedge clk);
    sync_in = 1'b1;
    #1 check("R9 reload off", {15'b0, cnt_reload}, 16'h0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      sync_in = (k < 3);
      check("R3 quiet", {15'b0, sync_out}, 16'h0);
    end
    sync_in = 1'b0;
  endtask

  task automatic t_tc();
    set_ctrl(2'd1, 1'b0);
    rd_addr = 4'd10; #1;
    check("R8 ctrl tc", rd_data, 16'h0100);
    tc_in = 1'b1; #1 check("R4 tc hi", {15'b0, sync_out}, 16'h1);
    tc_in = 1'b0; #1 check("R4 tc lo", {15'b0, sync_out}, 16'h0);
  endtask

  task automatic t_oneshot(logic [15:0] d);
    set_ctrl(2'd2, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd11; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 pulse", {15'b0, one_shot}, 16'h1);
    check("R5 out", {15'b0, sync_out}, 16'h1);
    @(negedge clk);
    check("R7 width", {15'b0, one_shot}, 16'h0);
    check("R5 out lo", {15'b0, sync_out}, 16'h0);
    rd_addr = 4'd10; #1;
    check("R7 ctrl kept", rd_data, 16'h0200);
    rd_addr = 4'd11; #1;
    check("R8 os read", rd_data, 16'h0000);
  endtask

  task automatic t_never();
    set_ctrl(2'd3, 1'b0);
    tc_in = 1'b1; sync_in = 1'b1;
    write(4'd11, 16'h0);
    for (int k = 0; k < 6; k++) begin
      check("R6 never", {15'b0, sync_out}, 16'h0);
      @(negedge clk);
    end
    tc_in = 1'b0; sync_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_delay();
    t_disable();
    t_tc();
    t_oneshot(16'hFFFF);
    t_oneshot(16'h0000);
    t_never();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule